// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display from edge values that software writes at run time. Two counters walk the pixels of a line and the lines of a frame, advancing once per cycle in which the pixel enable is high. Each sync, start, blank and total edge is a separate 16-bit register. Sync outputs, per-axis active windows and a combined active-display signal are all decoded from the counter values. The current pixel and line coordinates are brought out as ports.

A separate control word carries three things: a 3-bit pixel-clock select, a pair of flip-screen flags and a display-off flag. These are only passed to the ports for other blocks to use. Clock synthesis, scaling and pixel data are outside this block.

Every register write first goes to a holding copy. The value becomes live only at the start of the next frame, so one frame never mixes old and new timing. After reset the live values are the standard 384-pixel narrow mode. That mode has 454 pixels per line and 262 lines, which gives a frame of 118948 enabled cycles.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, both coordinates are 0. The live timing holds the narrow-mode defaults: line sync 42, line start 111, line blank 495, line total 454, frame sync 3, frame start 21, frame blank 245, frame total 262. The live control word is 0x0003, so pixClkSel is 3 and flipX, flipY and dispOff are 0.
- R2: On each clock edge with pixEn high, pixX counts from 0 to line total − 1 and then returns to 0. pixY advances by one on each such return and goes back to 0 after frame total − 1. With pixEn low, both coordinates hold.
- R3: hSync is high exactly while pixX is below the live line sync value.
- R4: vSync is high exactly while pixY is below the live frame sync value.
- R5: hActive is high when pixX lies in the window from line start up to (but not including) line blank, taken modulo line total. A blank value beyond the total therefore wraps into the start of the next line. The window width is blank − start.
- R6: vActive follows the same rule on pixY, using frame start, frame blank and frame total.
- R7: displayActive is the AND of hActive and vActive, forced low while dispOff is set. Sync keeps running while dispOff is set.
- R8: Register addresses are line sync 0, line start 1, line blank 2, line total 3, frame sync 4, frame start 5, frame blank 6, frame total 7, control 8. A write to any address from 9 to 15 has no effect.
- R9: A write lands in the holding copy. The live copy takes all holding values on the enabled edge that returns both counters to 0. Outputs therefore change timing or control only at a frame start.
- R10: Control word fields: bits 2:0 drive pixClkSel, bit 3 drives flipX, bit 4 drives flipY and bit 15 drives dispOff.
- R11: One frame lasts line total × frame total enabled cycles. This is 118948 with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixEn | input | 1 | Pixel enable; counters advance on edges where it is high |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register index |
| regWdata | input | 16 | Register write value |
| pixX | output | 16 | Current pixel within the line |
| pixY | output | 16 | Current line within the frame |
| hSync | output | 1 | Line sync pulse |
| vSync | output | 1 | Frame sync pulse |
| hActive | output | 1 | Pixel inside the horizontal display window |
| vActive | output | 1 | Line inside the vertical display window |
| displayActive | output | 1 | Combined active display |
| flipX | output | 1 | Flip flag X from the control word |
| flipY | output | 1 | Flip flag Y from the control word |
| pixClkSel | output | 3 | Pixel-clock select from the control word |
| dispOff | output | 1 | Display-off flag from the control word |

## Verification
The properties assume that each total is at least 1, that each start value is below its total, and that blank minus start does not exceed the total. Under these conditions the wrapped window is well defined and a counter never starts a frame beyond its new total.

The stimulus keeps to these limits. It loads the narrow-mode values, then a reduced 20 × 10 timing whose line blank passes the line total. It then changes only control bits. The pixel enable is held high for the long first frame and then driven with an irregular pattern, which exercises the hold behaviour.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef enum logic [3:0] {
    REG_HSYNC  = 4'd0,
    REG_HSTART = 4'd1,
    REG_HBLANK = 4'd2,
    REG_HTOTAL = 4'd3,
    REG_VSYNC  = 4'd4,
    REG_VSTART = 4'd5,
    REG_VBLANK = 4'd6,
    REG_VTOTAL = 4'd7,
    REG_CTRL   = 4'd8
  } rasterReg_e;

  localparam int NUM_REGS      = 9;
  localparam int CLKSEL_W      = 3;
  localparam int CTRL_FLIPX    = 3;
  localparam int CTRL_FLIPY    = 4;
  localparam int CTRL_OFF      = 15;
  localparam int NUM_AXES      = 2;

  // strobes from the counter control to the register datapath
  typedef struct packed {
    logic pixStep;
    logic lineEnd;
    logic frameEnd;
  } rasterStrobe_t;
endpackage

// File: rtl/raster_window.sv
module raster_window #(
  parameter int W = 16
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] start,
  input  logic [W-1:0] blank,
  input  logic [W-1:0] total,
  output logic         inWin
);
  logic [W:0] rel;
  logic [W:0] width;

  // distance from start, folded into one period of the axis
  always_comb begin
    if (pos >= start) rel = {1'b0, pos} - {1'b0, start};
    else              rel = {1'b0, pos} + {1'b0, total} - {1'b0, start};
    width = {1'b0, blank} - {1'b0, start};
    inWin = rel < width;
  end
endmodule

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pixEn,
  input  logic [W-1:0]  hTotal,
  input  logic [W-1:0]  vTotal,
  output logic [W-1:0]  hCnt,
  output logic [W-1:0]  vCnt,
  output rasterStrobe_t strobe
);
  logic [W:0] hNext;
  logic [W:0] vNext;

  always_comb begin
    hNext           = {1'b0, hCnt} + 1'b1;
    vNext           = {1'b0, vCnt} + 1'b1;
    strobe.pixStep  = pixEn;
    strobe.lineEnd  = pixEn && (hNext >= {1'b0, hTotal});
    strobe.frameEnd = strobe.lineEnd && (vNext >= {1'b0, vTotal});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strobe.pixStep) begin
      if (strobe.lineEnd) begin
        hCnt <= '0;
        vCnt <= strobe.frameEnd ? '0 : vNext[W-1:0];
      end else begin
        hCnt <= hNext[W-1:0];
      end
    end
  end
endmodule

// File: rtl/raster_datapath.sv
module raster_datapath
  import raster_pkg::*;
#(
  parameter int          W        = 16,
  parameter int          ADDR_W   = 4,
  parameter logic [15:0] INIT_HS  = 16'd42,
  parameter logic [15:0] INIT_HST = 16'd111,
  parameter logic [15:0] INIT_HBL = 16'd495,
  parameter logic [15:0] INIT_HT  = 16'd454,
  parameter logic [15:0] INIT_VS  = 16'd3,
  parameter logic [15:0] INIT_VST = 16'd21,
  parameter logic [15:0] INIT_VBL = 16'd245,
  parameter logic [15:0] INIT_VT  = 16'd262,
  parameter logic [15:0] INIT_CTL = 16'h0003
) (
  input  logic                clk,
  input  logic                rstN,
  input  rasterStrobe_t       strobe,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [W-1:0]        regWdata,
  input  logic [W-1:0]        hCnt,
  input  logic [W-1:0]        vCnt,
  output logic [W-1:0]        hTotal,
  output logic [W-1:0]        vTotal,
  output logic                hSync,
  output logic                vSync,
  output logic                hActive,
  output logic                vActive,
  output logic                displayActive,
  output logic                flipX,
  output logic                flipY,
  output logic [CLKSEL_W-1:0] pixClkSel,
  output logic                dispOff
);
  localparam int BASE_SYNC  = 0;
  localparam int BASE_START = 1;
  localparam int BASE_BLANK = 2;
  localparam int BASE_TOTAL = 3;
  localparam int AXIS_STEP  = 4;

  logic [W-1:0] shadowQ [NUM_REGS];
  logic [W-1:0] liveQ   [NUM_REGS];
  logic [W-1:0] axisPos [NUM_AXES];
  logic         axisWin [NUM_AXES];

  function automatic logic [W-1:0] resetVal(input int idx);
    logic [15:0] v;
    case (idx)
      0: v = INIT_HS;
      1: v = INIT_HST;
      2: v = INIT_HBL;
      3: v = INIT_HT;
      4: v = INIT_VS;
      5: v = INIT_VST;
      6: v = INIT_VBL;
      7: v = INIT_VT;
      default: v = INIT_CTL;
    endcase
    return W'(v);
  endfunction

  // holding copy takes writes; live copy loads at the frame boundary
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!rstN) begin
        shadowQ[i] <= resetVal(i);
        liveQ[i]   <= resetVal(i);
      end else begin
        if (regWe && (regAddr == ADDR_W'(i))) shadowQ[i] <= regWdata;
        if (strobe.frameEnd)                   liveQ[i]   <= shadowQ[i];
      end
    end
  end

  assign axisPos[0] = hCnt;
  assign axisPos[1] = vCnt;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    raster_window #(.W(W)) u_win (
      .pos   (axisPos[a]),
      .start (liveQ[a*AXIS_STEP + BASE_START]),
      .blank (liveQ[a*AXIS_STEP + BASE_BLANK]),
      .total (liveQ[a*AXIS_STEP + BASE_TOTAL]),
      .inWin (axisWin[a])
    );
  end

  always_comb begin
    hTotal        = liveQ[BASE_TOTAL];
    vTotal        = liveQ[AXIS_STEP + BASE_TOTAL];
    hSync         = hCnt < liveQ[BASE_SYNC];
    vSync         = vCnt < liveQ[AXIS_STEP + BASE_SYNC];
    hActive       = axisWin[0];
    vActive       = axisWin[1];
    dispOff       = liveQ[REG_CTRL][CTRL_OFF];
    flipX         = liveQ[REG_CTRL][CTRL_FLIPX];
    flipY         = liveQ[REG_CTRL][CTRL_FLIPY];
    pixClkSel     = liveQ[REG_CTRL][CLKSEL_W-1:0];
    displayActive = hActive && vActive && !dispOff;
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int          W        = 16,
  parameter int          ADDR_W   = 4,
  parameter logic [15:0] INIT_HS  = 16'd42,
  parameter logic [15:0] INIT_HST = 16'd111,
  parameter logic [15:0] INIT_HBL = 16'd495,
  parameter logic [15:0] INIT_HT  = 16'd454,
  parameter logic [15:0] INIT_VS  = 16'd3,
  parameter logic [15:0] INIT_VST = 16'd21,
  parameter logic [15:0] INIT_VBL = 16'd245,
  parameter logic [15:0] INIT_VT  = 16'd262,
  parameter logic [15:0] INIT_CTL = 16'h0003
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pixEn,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [W-1:0]        regWdata,
  output logic [W-1:0]        pixX,
  output logic [W-1:0]        pixY,
  output logic                hSync,
  output logic                vSync,
  output logic                hActive,
  output logic                vActive,
  output logic                displayActive,
  output logic                flipX,
  output logic                flipY,
  output logic [CLKSEL_W-1:0] pixClkSel,
  output logic                dispOff
);
  rasterStrobe_t strobe;
  logic [W-1:0]  hTotal;
  logic [W-1:0]  vTotal;

  raster_ctrl #(.W(W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .pixEn  (pixEn),
    .hTotal (hTotal),
    .vTotal (vTotal),
    .hCnt   (pixX),
    .vCnt   (pixY),
    .strobe (strobe)
  );

  raster_datapath #(
    .W(W), .ADDR_W(ADDR_W),
    .INIT_HS(INIT_HS), .INIT_HST(INIT_HST), .INIT_HBL(INIT_HBL), .INIT_HT(INIT_HT),
    .INIT_VS(INIT_VS), .INIT_VST(INIT_VST), .INIT_VBL(INIT_VBL), .INIT_VT(INIT_VT),
    .INIT_CTL(INIT_CTL)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .regWe         (regWe),
    .regAddr       (regAddr),
    .regWdata      (regWdata),
    .hCnt          (pixX),
    .vCnt          (pixY),
    .hTotal        (hTotal),
    .vTotal        (vTotal),
    .hSync         (hSync),
    .vSync         (vSync),
    .hActive       (hActive),
    .vActive       (vActive),
    .displayActive (displayActive),
    .flipX         (flipX),
    .flipY         (flipY),
    .pixClkSel     (pixClkSel),
    .dispOff       (dispOff)
  );
endmodule

// File: rtl/raster_timing_checker.sv
module raster_timing_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         pixEn,
  input logic [W-1:0] pixX,
  input logic [W-1:0] pixY,
  input logic         hSync,
  input logic         vSync,
  input logic         hActive,
  input logic         vActive,
  input logic         displayActive,
  input logic         flipX,
  input logic         flipY,
  input logic [2:0]   pixClkSel,
  input logic         dispOff
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |=> ($stable(pixX) && $stable(pixY)));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    pixEn |=> ((pixX == $past(pixX) + 1'b1) || (pixX == '0)));

  assert_line_R2: assert property (@(posedge clk) disable iff (!rstN)
    pixEn |=> ((pixX == '0) || $stable(pixY)));

  assert_hsync_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hSync) |-> (pixX == '0));

  assert_vsync_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vSync) |-> ((pixX == '0) && (pixY == '0)));

  assert_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    dispOff |-> !displayActive);

  assert_and_R7: assert property (@(posedge clk) disable iff (!rstN)
    displayActive |-> (hActive && vActive));

  assert_frame_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({pixClkSel, flipX, flipY, dispOff}) |-> ((pixX == '0) && (pixY == '0)));
endmodule

bind raster_timing_gen raster_timing_checker #(.W(W)) u_checker (
  .clk           (clk),
  .rstN          (rstN),
  .pixEn         (pixEn),
  .pixX          (pixX),
  .pixY          (pixY),
  .hSync         (hSync),
  .vSync         (vSync),
  .hActive       (hActive),
  .vActive       (vActive),
  .displayActive (displayActive),
  .flipX         (flipX),
  .flipY         (flipY),
  .pixClkSel     (pixClkSel),
  .dispOff       (dispOff)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rstN, pixEn, regWe;
  logic [3:0]  regAddr;
  logic [15:0] regWdata;
  logic [15:0] pixX, pixY;
  logic        hSync, vSync, hActive, vActive, displayActive;
  logic        flipX, flipY, dispOff;
  logic [2:0]  pixClkSel;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int enEdges = 0;
  int frameMark = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int mH, mV;
  int mShadow [9];
  int mLive   [9];
  int defaults [9] = '{42, 111, 495, 454, 3, 21, 245, 262, 3};

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .pixX(pixX), .pixY(pixY), .hSync(hSync), .vSync(vSync),
    .hActive(hActive), .vActive(vActive), .displayActive(displayActive),
    .flipX(flipX), .flipY(flipY), .pixClkSel(pixClkSel), .dispOff(dispOff)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at time %0t", tag, what, act, exp, $time);
    end
  endtask

  // window membership written as two ranges (this period and the wrapped one)
  function automatic bit inside2(input int p, input int s, input int b, input int t);
    return ((p >= s) && (p < b)) || ((p + t >= s) && (p + t < b));
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mH = 0; mV = 0;
      for (int i = 0; i < 9; i++) begin mShadow[i] = defaults[i]; mLive[i] = defaults[i]; end
    end else begin
      if (pixEn) begin
        enEdges++;
        if (mH + 1 >= mLive[3]) begin
          mH = 0;
          if (mV + 1 >= mLive[7]) begin
            mV = 0;
            for (int i = 0; i < 9; i++) mLive[i] = mShadow[i];
          end else mV++;
        end else mH++;
      end
      if (regWe && regAddr <= 4'd8) mShadow[regAddr] = int'(regWdata);
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      int ctl;
      bit eh, ev;
      ctl = mLive[8];
      eh  = inside2(mH, mLive[1], mLive[2], mLive[3]);
      ev  = inside2(mV, mLive[5], mLive[6], mLive[7]);
      check("R2", "pixX", int'(pixX), mH);
      check("R2", "pixY", int'(pixY), mV);
      check("R3", "hSync", int'(hSync), int'(mH < mLive[0]));
      check("R4", "vSync", int'(vSync), int'(mV < mLive[4]));
      check("R5", "hActive", int'(hActive), int'(eh));
      check("R6", "vActive", int'(vActive), int'(ev));
      check("R7", "displayActive", int'(displayActive), int'(eh && ev && !ctl[15]));
      check("R10", "pixClkSel", int'(pixClkSel), ctl & 7);
      check("R10", "flipX", int'(flipX), (ctl >> 3) & 1);
      check("R10", "flipY", int'(flipY), (ctl >> 4) & 1);
      check("R10", "dispOff", int'(dispOff), (ctl >> 15) & 1);
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic writeReg(input int a, input int d);
    @(negedge clk);
    pixEn = 1'b1; regWe = 1'b1; regAddr = 4'(a); regWdata = 16'(d);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // runs until the counters return to (0,0); reports enabled edges in the frame
  task automatic waitFrame(input bit gappy, output int n);
    do begin
      @(negedge clk);
      pixEn = gappy ? lfsr[0] : 1'b1;
      lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end while (!((pixX == 0) && (pixY == 0) && (enEdges != frameMark)));
    n = enEdges - frameMark;
    frameMark = enEdges;
  endtask

  initial begin
    int n;
    int hsRise, dispHigh;
    bit hsPrev;
    rstN = 1'b0; pixEn = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check("R1", "pixX", int'(pixX), 0);
    check("R1", "pixY", int'(pixY), 0);
    check("R1", "pixClkSel", int'(pixClkSel), 3);
    check("R1", "flipX", int'(flipX), 0);
    check("R1", "dispOff", int'(dispOff), 0);
    check("R1", "hSync", int'(hSync), 1);

    // standard narrow values rewritten, then a reduced timing queued for frame 2
    for (int i = 0; i < 8; i++) writeReg(i, defaults[i]);
    writeReg(8, 16'h000D);
    writeReg(12, 16'hFFFF);            // R8: outside the map, no effect
    writeReg(0, 3);  writeReg(1, 5);  writeReg(2, 22); writeReg(3, 20);
    writeReg(4, 2);  writeReg(5, 2);  writeReg(6, 8);  writeReg(7, 10);
    repeat (5) @(negedge clk);
    check("R9", "pixClkSel mid-frame", int'(pixClkSel), 3);
    check("R9", "flipX mid-frame", int'(flipX), 0);
    check("R9", "hSync still narrow timing", int'(hSync), int'(pixX < 42));

    waitFrame(1'b0, n);
    check("R11", "narrow frame length", n, 118948);
    check("R10", "pixClkSel after load", int'(pixClkSel), 5);
    check("R10", "flipX after load", int'(flipX), 1);
    check("R8", "control not hit by addr 12", int'(dispOff), 0);

    waitFrame(1'b0, n);
    check("R11", "reduced frame length", n, 200);
    waitFrame(1'b1, n);
    check("R2", "frame length with gaps", n, 200);

    // R7: display off keeps sync alive
    writeReg(8, 16'h8005);
    waitFrame(1'b1, n);
    hsRise = 0; dispHigh = 0; hsPrev = hSync;
    repeat (150) begin
      @(negedge clk);
      pixEn = 1'b1;
      if (hSync && !hsPrev) hsRise++;
      if (displayActive) dispHigh++;
      hsPrev = hSync;
    end
    check("R7", "dispOff", int'(dispOff), 1);
    check("R7", "displayActive while off", dispHigh, 0);
    check("R7", "sync rises while off", int'(hsRise > 0), 1);

    writeReg(8, 16'h0012);
    waitFrame(1'b0, n);
    waitFrame(1'b0, n);
    check("R10", "flipY", int'(flipY), 1);
    check("R10", "flipX", int'(flipX), 0);
    check("R10", "pixClkSel", int'(pixClkSel), 2);
    repeat (30) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule